// File: doc/BRIEF.md
# Configurable Round and Saturate Unit

This block post-processes a 44-bit two's-complement word, such as the output of a multiply-accumulate datapath. It first rounds the word at one bit position and then clamps it to a narrower signed range whose top bit is a second position. Both positions are fixed by parameters at elaboration time. The rounding position must lie in a window of low-order bits, and the clamp position in a window of high-order bits.

The clamp can be asymmetric, covering the full two's-complement range of the narrowed width. It can also be symmetric, which trims the negative end by one step of the rounded grid so that the positive and negative limits have equal magnitude. The rounding stage and the clamping stage can each be switched off by parameter. The processed word is sign-extended back to 44 bits and registered once, together with its valid bit and a flag that marks clamped results.

Top module: `round_sat_unit`

## Requirements
- R1: `out_valid` is high exactly one clock after a cycle in which `in_valid` was high at the rising edge. `out_data` and `out_sat` take the result of that input word in the same cycle.
- R2: With rounding on, the word is sign-extended to 45 bits and 2^(ROUND_BIT-1) is added, so ties round toward plus infinity. Bits [ROUND_BIT-1:0] are then cleared. ROUND_BIT is restricted to 6..21.
- R3: With clamping on, the result width is n = CLAMP_BIT+1, where CLAMP_BIT is restricted to 28..43. In asymmetric mode the result is limited to the range -2^(n-1) to 2^(n-1)-1. With n = 36, input 0x5926AC01342 gives 0x007FFFFFFFF and input 0xFADA38D2210 gives 0xFF800000000.
- R4: In symmetric mode the upper limit is still 2^(n-1)-1. The lower limit is -2^(n-1)+2^ROUND_BIT when rounding is on, and -2^(n-1)+1 when rounding is off. With n = 36, no rounding and input 0xFADA38D2210, the result is 0xFF800000001.
- R5: Clamping acts on the rounded value. A carry produced by rounding that pushes the value past the upper limit is clamped and flagged.
- R6: The output is the clamped value sign-extended to 44 bits. `out_sat` is high exactly when the value was replaced by a limit.
- R7: With rounding off, the input reaches the clamp unchanged. With clamping off, the rounded 45-bit value is truncated to 44 bits, so it wraps, and `out_sat` stays low.
- R8: While `rst_n` is low, `out_valid`, `out_sat` and `out_data` are 0, and they go to 0 without waiting for a clock edge.
- R9: In a cycle where `in_valid` is low at the edge, `out_data` and `out_sat` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | Qualifies `in_data` |
| in_data | input | 44 | Two's-complement input word |
| out_valid | output | 1 | Result valid, one cycle after the input |
| out_data | output | 44 | Rounded and clamped word, sign-extended |
| out_sat | output | 1 | High when the result was clamped |

## Verification
The assertions assume that `in_valid` is a known level at every rising edge after reset and that it is held low while reset is asserted. Under those conditions the delayed-valid and hold properties hold from the first enabled edge. They also assume that the parameters lie inside their windows, because the limits are derived from them. The bench drives all inputs on falling edges, keeps `in_valid` low before and during each reset, and only uses parameter sets inside the allowed windows.

// File: rtl/rsu_pkg.sv
package rsu_pkg;
  localparam int WORD_W   = 44;
  localparam int EXT_W    = WORD_W + 1;
  localparam int ROUND_LO = 6;
  localparam int ROUND_HI = 21;
  localparam int CLAMP_LO = 28;
  localparam int CLAMP_HI = 43;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [EXT_W-1:0]  ext_t;
endpackage

// File: rtl/rsu_round.sv
module rsu_round
  import rsu_pkg::*;
#(
  parameter int ROUND_BIT = 8,
  parameter bit ROUND_ON  = 1'b1
) (
  input  word_t word_i,
  output ext_t  rnd_o
);
  localparam ext_t ONE  = {{(EXT_W-1){1'b0}}, 1'b1};
  localparam ext_t HALF = ONE << (ROUND_BIT - 1);
  localparam ext_t KEEP = ~((ONE << ROUND_BIT) - ONE);

  ext_t widened;
  assign widened = {word_i[WORD_W-1], word_i};

  generate
    if (ROUND_ON) begin : g_round
      ext_t biased;
      always_comb begin
        biased = widened + HALF;
        rnd_o  = biased & KEEP;
      end
    end else begin : g_pass
      assign rnd_o = widened;
    end
  endgenerate
endmodule

// File: rtl/rsu_clamp.sv
module rsu_clamp
  import rsu_pkg::*;
#(
  parameter int ROUND_BIT       = 8,
  parameter bit ROUND_ON        = 1'b1,
  parameter int CLAMP_BIT       = 35,
  parameter bit CLAMP_ON        = 1'b1,
  parameter bit CLAMP_SYMMETRIC = 1'b1
) (
  input  ext_t  val_i,
  output word_t val_o,
  output logic  hit_o
);
  localparam int NBITS = CLAMP_BIT + 1;
  localparam logic signed [EXT_W-1:0] ONE_S = {{(EXT_W-1){1'b0}}, 1'b1};
  localparam logic signed [EXT_W-1:0] STEP  =
    CLAMP_SYMMETRIC ? (ROUND_ON ? (ONE_S <<< ROUND_BIT) : ONE_S) : '0;
  localparam logic signed [EXT_W-1:0] UPPER = (ONE_S <<< (NBITS - 1)) - ONE_S;
  localparam logic signed [EXT_W-1:0] LOWER = STEP - (ONE_S <<< (NBITS - 1));

  generate
    if (CLAMP_ON) begin : g_clamp
      logic signed [EXT_W-1:0] sval;
      logic signed [EXT_W-1:0] picked;
      always_comb begin
        sval   = $signed(val_i);
        picked = sval;
        hit_o  = 1'b0;
        if (sval > UPPER) begin
          picked = UPPER;
          hit_o  = 1'b1;
        end else if (sval < LOWER) begin
          picked = LOWER;
          hit_o  = 1'b1;
        end
        val_o = picked[WORD_W-1:0];
      end
    end else begin : g_wrap
      assign val_o = val_i[WORD_W-1:0];
      assign hit_o = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/round_sat_unit.sv
module round_sat_unit
  import rsu_pkg::*;
#(
  parameter int ROUND_BIT       = 8,
  parameter bit ROUND_ON        = 1'b1,
  parameter int CLAMP_BIT       = 35,
  parameter bit CLAMP_ON        = 1'b1,
  parameter bit CLAMP_SYMMETRIC = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [43:0] in_data,
  output logic        out_valid,
  output logic [43:0] out_data,
  output logic        out_sat
);
  ext_t  rounded;
  word_t clamped;
  logic  clamp_hit;

  logic  valid_d, valid_q;
  word_t data_d, data_q;
  logic  sat_d, sat_q;

  rsu_round #(
    .ROUND_BIT (ROUND_BIT),
    .ROUND_ON  (ROUND_ON)
  ) round_i (
    .word_i (in_data),
    .rnd_o  (rounded)
  );

  rsu_clamp #(
    .ROUND_BIT       (ROUND_BIT),
    .ROUND_ON        (ROUND_ON),
    .CLAMP_BIT       (CLAMP_BIT),
    .CLAMP_ON        (CLAMP_ON),
    .CLAMP_SYMMETRIC (CLAMP_SYMMETRIC)
  ) clamp_i (
    .val_i (rounded),
    .val_o (clamped),
    .hit_o (clamp_hit)
  );

  always_comb begin
    valid_d = in_valid;
    data_d  = data_q;
    sat_d   = sat_q;
    if (in_valid) begin
      data_d = clamped;
      sat_d  = clamp_hit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
      sat_q   <= 1'b0;
    end else begin
      valid_q <= valid_d;
      data_q  <= data_d;
      sat_q   <= sat_d;
    end
  end

  assign out_valid = valid_q;
  assign out_data  = data_q;
  assign out_sat   = sat_q;

  localparam logic signed [WORD_W-1:0] ONE_W = {{(WORD_W-1){1'b0}}, 1'b1};
  localparam logic signed [WORD_W-1:0] TOP_W = ONE_W <<< CLAMP_BIT;
  localparam logic signed [WORD_W-1:0] CHK_MAX = TOP_W - ONE_W;
  localparam logic signed [WORD_W-1:0] CHK_MIN = -TOP_W +
    (CLAMP_SYMMETRIC ? (ROUND_ON ? (ONE_W <<< ROUND_BIT) : ONE_W) : '0);

  AST_VALID_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(in_valid)); // R1

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(in_valid) |-> ($stable(out_data) && $stable(out_sat))); // R9

  generate
    if (ROUND_ON) begin : g_rnd_chk
      AST_ROUND_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_sat) |-> (out_data[ROUND_BIT-1:0] == '0)); // R2
    end
    if (CLAMP_ON) begin : g_clamp_chk
      AST_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($signed(out_data) <= CHK_MAX && $signed(out_data) >= CHK_MIN)); // R3
      AST_FLAG_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        out_sat |-> ($signed(out_data) == CHK_MAX || $signed(out_data) == CHK_MIN)); // R6
    end
  endgenerate
endmodule

// File: tb/round_sat_unit_tb_top.sv
module round_sat_unit_tb_top;
  logic clk;
  logic rst_n;
  logic in_valid;
  logic [43:0] in_data;

  logic v_i, v_a, v_s, v_n;
  logic [43:0] d_i, d_a, d_s, d_n;
  logic f_i, f_a, f_s, f_n;

  int total = 0;
  int bad   = 0;

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // rounding at bit 8, clamp at bit 35 (n = 36), symmetric
  round_sat_unit #(.ROUND_BIT(8), .ROUND_ON(1'b1), .CLAMP_BIT(35), .CLAMP_ON(1'b1),
                   .CLAMP_SYMMETRIC(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .out_valid(v_i), .out_data(d_i), .out_sat(f_i));
  // no rounding, n = 36, asymmetric
  round_sat_unit #(.ROUND_BIT(6), .ROUND_ON(1'b0), .CLAMP_BIT(35), .CLAMP_ON(1'b1),
                   .CLAMP_SYMMETRIC(1'b0)) dut_a (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .out_valid(v_a), .out_data(d_a), .out_sat(f_a));
  // no rounding, n = 36, symmetric
  round_sat_unit #(.ROUND_BIT(6), .ROUND_ON(1'b0), .CLAMP_BIT(35), .CLAMP_ON(1'b1),
                   .CLAMP_SYMMETRIC(1'b1)) dut_s (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .out_valid(v_s), .out_data(d_s), .out_sat(f_s));
  // rounding at bit 21, clamp off
  round_sat_unit #(.ROUND_BIT(21), .ROUND_ON(1'b1), .CLAMP_BIT(43), .CLAMP_ON(1'b0),
                   .CLAMP_SYMMETRIC(1'b0)) dut_n (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .out_valid(v_n), .out_data(d_n), .out_sat(f_n));

  localparam int NVEC = 14;
  localparam logic [43:0] VEC [NVEC] = '{
    44'h5926AC01342, 44'hFADA38D2210, 44'h00000000000, 44'h7FFFFFFFFFF,
    44'h80000000000, 44'h00000000180, 44'h0000000017F, 44'hFFFFFFFFF80,
    44'h007FFFFFF80, 44'hFF800000000, 44'hFF800000080, 44'h00123456789,
    44'hFFFEDCBA987, 44'h7FFFFF00000
  };

  task automatic check(input string req, input string what,
                       input logic [43:0] act, input logic [43:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  // independent model of R2..R7 in 64-bit arithmetic
  function automatic void model(input logic [43:0] d, input bit rnd_on, input int rbit,
                                input bit clp_on, input int cbit, input bit sym,
                                output logic [43:0] q, output logic f);
    longint v, hi, lo;
    v = longint'($signed(d));
    if (rnd_on) begin
      v = v + (longint'(1) <<< (rbit - 1));
      v = v & ~((longint'(1) <<< rbit) - 1);
    end
    f = 1'b0;
    if (clp_on) begin
      hi = (longint'(1) <<< cbit) - 1;
      lo = -(longint'(1) <<< cbit);
      if (sym) lo = lo + (rnd_on ? (longint'(1) <<< rbit) : longint'(1));
      if (v > hi) begin v = hi; f = 1'b1; end
      else if (v < lo) begin v = lo; f = 1'b1; end
    end
    q = v[43:0];
  endfunction

  task automatic check_all(input logic [43:0] d);
    logic [43:0] q;
    logic f;
    model(d, 1'b1, 8, 1'b1, 35, 1'b1, q, f);
    check("R2 R4 R5 R6", "dut_i data", d_i, q);
    check("R6", "dut_i flag", {43'd0, f_i}, {43'd0, f});
    model(d, 1'b0, 6, 1'b1, 35, 1'b0, q, f);
    check("R3 R7", "dut_a data", d_a, q);
    check("R6", "dut_a flag", {43'd0, f_a}, {43'd0, f});
    model(d, 1'b0, 6, 1'b1, 35, 1'b1, q, f);
    check("R4 R7", "dut_s data", d_s, q);
    check("R6", "dut_s flag", {43'd0, f_s}, {43'd0, f});
    model(d, 1'b1, 21, 1'b0, 43, 1'b0, q, f);
    check("R7", "dut_n data", d_n, q);
    check("R7", "dut_n flag", {43'd0, f_n}, 44'd0);
  endtask

  initial begin
    #2_000_000;
    total++;
    bad++;
    $display("FAIL watchdog expired act=%0d exp=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [43:0] held;
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_data  = '0;
    repeat (3) @(negedge clk);
    check("R8", "reset valid", {43'd0, v_i}, 44'd0);
    check("R8", "reset data", d_i, 44'd0);
    check("R8", "reset flag", {43'd0, f_i}, 44'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // table walk: back-to-back valid words
    in_valid = 1'b1;
    in_data  = VEC[0];
    for (int k = 0; k < NVEC; k++) begin
      @(negedge clk);
      check("R1", "valid", {43'd0, v_i}, 44'd1);
      check_all(VEC[k]);
      if (k + 1 < NVEC) in_data = VEC[k + 1];
    end
    in_valid = 1'b0;

    // literal expectations from the requirement examples
    in_valid = 1'b1;
    in_data  = 44'h5926AC01342;
    @(negedge clk);
    check("R3", "pos asym", d_a, 44'h007FFFFFFFF);
    check("R4", "pos sym", d_s, 44'h007FFFFFFFF);
    in_data = 44'hFADA38D2210;
    @(negedge clk);
    check("R3", "neg asym", d_a, 44'hFF800000000);
    check("R4", "neg sym", d_s, 44'hFF800000001);
    check("R4", "neg sym rounded", d_i, 44'hFF800000100);
    // rounding carry pushes past the upper limit
    in_data = 44'h007FFFFFF80;
    @(negedge clk);
    check("R5", "carry clamp data", d_i, 44'h007FFFFFFFF);
    check("R5", "carry clamp flag", {43'd0, f_i}, 44'd1);
    check("R5", "no carry no flag", {43'd0, f_a}, 44'd0);
    // wrap with clamping off
    in_data = 44'h7FFFFFFFFFF;
    @(negedge clk);
    check("R7", "wrap", d_n, 44'h80000000000);
    in_data = 44'h00000000080;
    @(negedge clk);
    check("R2", "tie rounds up", d_i, 44'h00000000100);
    held = d_i;

    // idle: inputs change but nothing is captured
    in_valid = 1'b0;
    in_data  = 44'h80000000000;
    @(negedge clk);
    check("R1", "valid drops", {43'd0, v_i}, 44'd0);
    @(negedge clk);
    check("R9", "data held", d_i, held);
    check("R9", "flag held", {43'd0, f_i}, 44'd0);

    // asynchronous reset mid-run
    in_valid = 1'b1;
    in_data  = 44'h7FFFFFFFFFF;
    @(negedge clk);
    in_valid = 1'b0;
    #1;
    rst_n = 1'b0;
    #0.5;
    check("R8", "async valid", {43'd0, v_i}, 44'd0);
    check("R8", "async data", d_i, 44'd0);
    check("R8", "async flag", {43'd0, f_i}, 44'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule